// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a 9-bit first-in first-out queue that connects two unrelated clock domains. A producer pushes words on the write clock, and a consumer takes them on the read clock. The queue works in fall-through mode. The oldest stored word is moved into an output register on its own, so it appears on the data output without any read request. A read enable then accepts that word, and the next one takes its place. Because the output register holds one word on top of the RAM, the queue holds up to DEPTH+1 words.

Each side has its own synchronous reset. Each side also computes its own status flags from its own pointers and from Gray-coded copies of the other side's pointers, which pass through two-flop synchronizers. The write side drives the ready-to-accept flag, almost-full and half-full. The read side drives the data-valid flag and almost-empty. Every flag is active low.

The write side is a two-state machine. ACCEPT moves to STALL when the RAM occupancy reaches DEPTH, and STALL moves back to ACCEPT once a read frees a slot. The read side is also a two-state machine. EMPTY moves to FULL when the RAM holds a word to load. FULL moves back to EMPTY when a word is taken and the RAM has nothing left to load. FULL stays in FULL when a take and a reload happen on the same edge. The threshold offsets for the almost flags are parameters fixed at build time.

Top module: `ffw_fifo`

## Requirements
- R1: After reset is applied in both domains, in_ready_n=0, out_ready_n=1, almost_empty_n=0, almost_full_n=1 and half_full_n=1.
- R2: A word written into an empty queue appears on dout with out_ready_n=0 within four read-clock edges, with no read enable asserted.
- R3: Words leave in write order. A read (rd_en=1 while out_ready_n=0, sampled on a rising read clock edge) advances dout to the next word. While rd_en=0, dout and out_ready_n hold.
- R4: Once the flags have settled, in_ready_n=1 exactly when the stored count equals DEPTH+1. The RAM never holds more than DEPTH words.
- R5: A write attempted while in_ready_n=1 is ignored. The stored words and their count stay unchanged.
- R6: A read attempted while out_ready_n=1 is ignored. No phantom word is later delivered, and no real word is lost.
- R7: Once settled, almost_empty_n=0 exactly when the stored count is at most PAE_OFS.
- R8: Once settled, almost_full_n=0 exactly when the stored count is at least DEPTH+1-PAF_OFS.
- R9: Once settled, half_full_n=0 exactly when the stored count exceeds (DEPTH+1)/2, using integer division.
- R10: When a word is read from a queue holding DEPTH+1 words, in_ready_n returns to 0 within four write-clock edges of the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous reset, write domain, active high |
| wr_en | input | 1 | Write request |
| din | input | DW (9) | Write data |
| in_ready_n | output | 1 | Low when a write will be accepted |
| almost_full_n | output | 1 | Low when count is at least DEPTH+1-PAF_OFS |
| half_full_n | output | 1 | Low when count exceeds (DEPTH+1)/2 |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous reset, read domain, active high |
| rd_en | input | 1 | Read request, accepts the word on dout |
| out_en | input | 1 | Drives dout when high; dout is high impedance when low |
| dout | output | DW (9) | Oldest stored word |
| out_ready_n | output | 1 | Low when dout holds a valid word |
| almost_empty_n | output | 1 | Low when count is at most PAE_OFS |

## Verification
The bench fills the queue to every level from 0 to DEPTH+1, then drains it one word at a time, checking all five flags at each level. An off-by-one in any threshold, or a full condition that counts only the RAM and stalls one word early, shows up as a wrong flag at a single level. It hammers a full queue with writes and an empty queue with reads. A pointer that moves while blocked would show up as an overwritten word, a duplicated word or a phantom word in the drained sequence. It also measures the first-word latency and the recovery of in_ready_n after a read from full. A long concurrent stream on the two unrelated clocks exposes Gray-crossing errors as reordered or corrupted data.

// File: rtl/ffw_pkg.sv
package ffw_pkg;

    typedef enum logic {W_ACCEPT, W_STALL} wr_state_e;
    typedef enum logic {R_EMPTY, R_FULL} rd_state_e;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ffw_sync.sv
module ffw_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/ffw_wr_ctrl.sv
module ffw_wr_ctrl
    import ffw_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int PAF_OFS = 3,
    parameter int PW      = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rram_gs,
    input  logic [PW-1:0] rgone_gs,
    output logic          wr_fire,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wgray,
    output logic          in_ready_n,
    output logic          almost_full_n,
    output logic          half_full_n
);
    localparam int TOTAL = DEPTH + 1;

    wr_state_e     state, state_nxt;
    logic [PW-1:0] wptr_nxt, rram_b, rgone_b, used_nxt, level_nxt, used_now;

    assign wr_fire    = wr_en && (state == W_ACCEPT);
    assign in_ready_n = (state == W_STALL);

    always_comb begin
        rram_b    = PW'(from_gray(32'(rram_gs)));
        rgone_b   = PW'(from_gray(32'(rgone_gs)));
        wptr_nxt  = wptr + PW'(wr_fire);
        used_nxt  = wptr_nxt - rram_b;
        level_nxt = wptr_nxt - rgone_b;
        used_now  = wptr - rram_b;
        unique case (state)
            W_ACCEPT: state_nxt = (used_nxt >= PW'(DEPTH)) ? W_STALL : W_ACCEPT;
            W_STALL:  state_nxt = (used_nxt <  PW'(DEPTH)) ? W_ACCEPT : W_STALL;
            default:  state_nxt = W_ACCEPT;
        endcase
    end

    // state and pointer register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W_ACCEPT;
            wptr  <= '0;
            wgray <= '0;
        end else begin
            state <= state_nxt;
            wptr  <= wptr_nxt;
            wgray <= PW'(to_gray(32'(wptr_nxt)));
        end
    end

    // flag outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            almost_full_n <= 1'b1;
            half_full_n   <= 1'b1;
        end else begin
            almost_full_n <= !(level_nxt >= PW'(TOTAL - PAF_OFS));
            half_full_n   <= !(level_nxt >  PW'(TOTAL / 2));
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        used_now <= PW'(DEPTH));

    p_blocked_write_r5: assert property (@(posedge clk) disable iff (rst)
        (in_ready_n && wr_en) |=> $stable(wptr));

    p_gray_step_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!in_ready_n && almost_full_n && half_full_n));
endmodule

// File: rtl/ffw_rd_ctrl.sv
module ffw_rd_ctrl
    import ffw_pkg::*;
#(
    parameter int DW      = 9,
    parameter int DEPTH   = 16,
    parameter int PAE_OFS = 3,
    parameter int PW      = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    input  logic [DW-1:0] ram_q,
    output logic [PW-1:0] rram,
    output logic [PW-1:0] rram_gray,
    output logic [PW-1:0] rgone_gray,
    output logic [DW-1:0] q_reg,
    output logic          out_ready_n,
    output logic          almost_empty_n
);
    rd_state_e     state, state_nxt;
    logic [PW-1:0] rgone, wb, rram_nxt, rgone_nxt, level_nxt;
    logic          ram_avail, take, load;

    assign out_ready_n = (state == R_EMPTY);

    always_comb begin
        wb        = PW'(from_gray(32'(wgray_s)));
        ram_avail = (wb != rram);
        take      = rd_en && (state == R_FULL);
        load      = ram_avail && ((state == R_EMPTY) || take);
        rram_nxt  = rram + PW'(load);
        rgone_nxt = rgone + PW'(take);
        level_nxt = wb - rgone_nxt;
        unique case (state)
            R_EMPTY: state_nxt = ram_avail ? R_FULL : R_EMPTY;
            R_FULL:  state_nxt = (take && !ram_avail) ? R_EMPTY : R_FULL;
            default: state_nxt = R_EMPTY;
        endcase
    end

    // state and pointer register
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= R_EMPTY;
            rram       <= '0;
            rgone      <= '0;
            rram_gray  <= '0;
            rgone_gray <= '0;
        end else begin
            state      <= state_nxt;
            rram       <= rram_nxt;
            rgone      <= rgone_nxt;
            rram_gray  <= PW'(to_gray(32'(rram_nxt)));
            rgone_gray <= PW'(to_gray(32'(rgone_nxt)));
        end
    end

    // data and flag outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            q_reg          <= '0;
            almost_empty_n <= 1'b0;
        end else begin
            if (load) q_reg <= ram_q;
            almost_empty_n <= !(level_nxt <= PW'(PAE_OFS));
        end
    end

    p_hold_output_r3: assert property (@(posedge clk) disable iff (rst)
        (!out_ready_n && !rd_en) |=> (!out_ready_n && $stable(q_reg)));

    p_blocked_read_r6: assert property (@(posedge clk) disable iff (rst)
        (out_ready_n && rd_en) |=> $stable(rgone));

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (out_ready_n && !almost_empty_n));
endmodule

// File: rtl/ffw_fifo.sv
module ffw_fifo #(
    parameter int DW      = 9,
    parameter int DEPTH   = 16,
    parameter int PAE_OFS = 3,
    parameter int PAF_OFS = 3
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    output logic          in_ready_n,
    output logic          almost_full_n,
    output logic          half_full_n,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_en,
    input  logic          out_en,
    output logic [DW-1:0] dout,
    output logic          out_ready_n,
    output logic          almost_empty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] ram_q, q_reg;
    logic [PW-1:0] wptr, wgray, wgray_s;
    logic [PW-1:0] rram, rram_gray, rgone_gray, rram_gs, rgone_gs;
    logic          wr_fire;

    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[wptr[AW-1:0]] <= din;
    end

    assign ram_q = mem[rram[AW-1:0]];
    assign dout  = out_en ? q_reg : 'z;

    ffw_wr_ctrl #(.DEPTH(DEPTH), .PAF_OFS(PAF_OFS), .PW(PW)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en),
        .rram_gs(rram_gs), .rgone_gs(rgone_gs),
        .wr_fire(wr_fire), .wptr(wptr), .wgray(wgray),
        .in_ready_n(in_ready_n), .almost_full_n(almost_full_n),
        .half_full_n(half_full_n)
    );

    ffw_rd_ctrl #(.DW(DW), .DEPTH(DEPTH), .PAE_OFS(PAE_OFS), .PW(PW)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en),
        .wgray_s(wgray_s), .ram_q(ram_q),
        .rram(rram), .rram_gray(rram_gray), .rgone_gray(rgone_gray),
        .q_reg(q_reg), .out_ready_n(out_ready_n),
        .almost_empty_n(almost_empty_n)
    );

    ffw_sync #(.W(PW)) u_sync_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
    );
    ffw_sync #(.W(PW)) u_sync_r2w_ram (
        .clk(wr_clk), .rst(wr_rst), .d(rram_gray), .q(rram_gs)
    );
    ffw_sync #(.W(PW)) u_sync_r2w_gone (
        .clk(wr_clk), .rst(wr_rst), .d(rgone_gray), .q(rgone_gs)
    );
endmodule

// File: tb/ffw_fifo_tb.sv
`timescale 1ns/1ps
module ffw_fifo_tb;
    localparam int DW = 9, DEPTH = 16, PAE = 3, PAF = 3;
    localparam int TOTAL = DEPTH + 1;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst = 1, rd_rst = 1, wr_en = 0, rd_en = 0, out_en = 1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic in_ready_n, almost_full_n, half_full_n, out_ready_n, almost_empty_n;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    ffw_fifo #(.DW(DW), .DEPTH(DEPTH), .PAE_OFS(PAE), .PAF_OFS(PAF)) u_dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .din(din),
        .in_ready_n(in_ready_n), .almost_full_n(almost_full_n),
        .half_full_n(half_full_n), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_en(rd_en), .out_en(out_en), .dout(dout),
        .out_ready_n(out_ready_n), .almost_empty_n(almost_empty_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        wr_en = 0; rd_en = 0; wr_rst = 1; rd_rst = 1;
        repeat (5) @(negedge rd_clk);
        wr_rst = 0; rd_rst = 0;
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge wr_clk);
        while (in_ready_n) @(negedge wr_clk);
        wr_en = 1; din = v;
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic pop(input string tag, input int exp);
        @(negedge rd_clk);
        while (out_ready_n) @(negedge rd_clk);
        chk(tag, int'(dout), exp);
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge rd_clk);
    endtask

    task automatic check_level(input int k);
        chk($sformatf("R4 in_ready_n level %0d", k), int'(in_ready_n), int'(k == TOTAL));
        chk($sformatf("R3 out_ready_n level %0d", k), int'(out_ready_n), int'(k == 0));
        chk($sformatf("R7 almost_empty_n level %0d", k), int'(almost_empty_n), int'(!(k <= PAE)));
        chk($sformatf("R8 almost_full_n level %0d", k), int'(almost_full_n), int'(!(k >= TOTAL - PAF)));
        chk($sformatf("R9 half_full_n level %0d", k), int'(half_full_n), int'(!(k > TOTAL / 2)));
    endtask

    initial begin
        #900000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state
        do_reset();
        @(negedge wr_clk);
        chk("R1 in_ready_n", int'(in_ready_n), 0);
        chk("R1 out_ready_n", int'(out_ready_n), 1);
        chk("R1 almost_empty_n", int'(almost_empty_n), 0);
        chk("R1 almost_full_n", int'(almost_full_n), 1);
        chk("R1 half_full_n", int'(half_full_n), 1);

        // R2: fall-through latency of the first word
        push(9'h155);
        n = 0;
        while (out_ready_n && n < 8) begin
            @(negedge rd_clk);
            n++;
        end
        chk("R2 first word latency within 4", int'(n <= 4), 1);
        chk("R2 first word on dout", int'(dout), 'h155);

        // sweep every fill level, then drain with flags at each level
        for (int k = 0; k <= TOTAL; k++) begin
            do_reset();
            for (int i = 0; i < k; i++) push(DW'((k * 19 + i) % 512));
            settle();
            check_level(k);
            for (int i = 0; i < k; i++) begin
                pop("R3 sweep order", (k * 19 + i) % 512);
                settle();
                check_level(k - 1 - i);
            end
        end

        // R10: in_ready_n recovery after a read from full
        do_reset();
        for (int i = 0; i < TOTAL; i++) push(DW'(i + 100));
        settle();
        chk("R4 full at DEPTH+1", int'(in_ready_n), 1);
        pop("R3 first of full", 100);
        n = 0;
        while (in_ready_n && n < 10) begin
            @(negedge wr_clk);
            n++;
        end
        chk("R10 ready recovery within 4", int'(n <= 4), 1);
        push(9'h1F0);
        settle();
        check_level(TOTAL);

        // R5: writes while full are ignored
        do_reset();
        for (int i = 0; i < TOTAL; i++) push(DW'(i * 3 + 7));
        settle();
        @(negedge wr_clk);
        wr_en = 1; din = 9'h0AA;
        repeat (6) @(negedge wr_clk);
        wr_en = 0;
        settle();
        check_level(TOTAL);
        for (int i = 0; i < TOTAL; i++) pop("R5 contents after blocked writes", i * 3 + 7);
        settle();
        chk("R5 no extra word", int'(out_ready_n), 1);

        // R6: reads while empty are ignored
        do_reset();
        @(negedge rd_clk);
        rd_en = 1;
        repeat (6) @(negedge rd_clk);
        rd_en = 0;
        push(9'h011);
        push(9'h022);
        pop("R6 first after blocked reads", 'h011);
        pop("R6 second after blocked reads", 'h022);
        settle();
        check_level(0);
        chk("R6 no phantom word", int'(out_ready_n), 1);

        // R3: concurrent stream across the two clocks
        do_reset();
        fork
            for (int i = 0; i < 200; i++) push(DW'((i * 37 + 5) % 512));
            for (int i = 0; i < 200; i++) pop("R3 stream order", (i * 37 + 5) % 512);
        join
        settle();
        check_level(0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule